// File: doc/BRIEF.md
# ECC Error Injection Controller

This block sits in the write data path between a memory controller and the 72-bit code word stored in ECC memory. The word is taken after check-bit generation and treated as two 36-bit halves. While the block is armed, a write whose address passes a programmable filter has chosen bits of the selected half or halves inverted on the way to memory. Other writes pass through unchanged. Either way the write leaves the block one clock cycle after it enters.

The address filter has six fields: module select, rank, channel, bank, page and column. Each field holds a compare value and its own match-anything flag. Software programs the filter, the flip mask, the half selector, the injection type and the arm control through a small register port. All of these read back. A saturating counter reports how many injections have taken place since the block was last armed.

An injection is either one-shot or continuous. A one-shot injection disarms the block after the first hit. A continuous injection corrupts every matching write until software disarms the block.

Top module: `ecc_inject_ctrl`

## Requirements
- R1: Reset state:
  - the block is disarmed; type, section, mask and counter are zero;
  - every filter field has its match-anything flag set and a value of zero;
  - `out_valid` is 0.
- R2: Register map (register port `reg_addr`):
  - 0 arm control: reads 1 when armed;
  - 1 type, bits [2:0];
  - 2 section, bits [1:0];
  - 3 flip mask, bits [35:0];
  - 4 to 9 filter fields in the order module, rank, channel, bank, page, column; the value sits in the low bits, masked to the field width (2,2,2,3,16,10), and the match-anything flag is bit 63;
  - 10 injection counter, read-only; writes to it are ignored;
  - every other address reads zero.
  - All written registers read back what was stored.
- R3: A write matches only when every filter field either has its match-anything flag set or equals the corresponding address input.
- R4: The section register selects the affected halves:
  - 1 selects the lower half, code bits [35:0];
  - 2 selects the upper half, bits [71:36];
  - 3 selects both halves;
  - 0 selects none, so the word is unchanged even on a counted hit.
- R5: With type bit 1 set, the 36-bit flip mask is XORed onto each selected half.
- R6: With type bit 2 set, the top bit of each selected half is inverted: code bit 35 for the lower half, bit 71 for the upper half. When bit 1 is also set, this inversion combines by XOR with the mask.
- R7: With type bit 0 clear (one-shot), the first hit disarms the block; the following matching writes pass unchanged.
- R8: With type bit 0 set (continuous), every matching write is corrupted until software writes zero to the arm control.
- R9: Arm control writes:
  - writing a nonzero value arms the block and clears the counter;
  - writing zero disarms it.
  - A write to the arm control in the same cycle as a hit takes precedence over the one-shot self-disarm. That hit itself is still judged and corrupted with the settings held before that edge.
- R10: The counter increments by one on every hit and stops at its maximum (255).
- R11: Writes that are invalid, do not match, or arrive while disarmed pass through unchanged, are not counted, and do not consume a one-shot. `out_valid`, `out_code` and `out_injected` follow the inputs by exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address (write and read) |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data for `reg_addr`, combinational |
| in_valid | input | 1 | A memory write is present this cycle |
| in_dimm | input | 2 | Module select of the write address |
| in_rank | input | 2 | Rank of the write address |
| in_chan | input | 2 | Channel of the write address |
| in_bank | input | 3 | Bank of the write address |
| in_page | input | 16 | Page (row) of the write address |
| in_col | input | 10 | Column of the write address |
| in_code | input | 72 | Code word after check-bit generation |
| out_valid | output | 1 | Registered write valid |
| out_code | output | 72 | Registered, possibly corrupted code word |
| out_injected | output | 1 | The write leaving this cycle was a hit |

## Verification
A register write to the arm control can fall on the same clock edge as a matching data write that is itself a hit.

The bench provokes this in two ways:
- a continuous injection is disarmed in the same cycle as a matching write;
- a one-shot injection is re-armed in the same cycle as its own hit.

Both cases are judged by the scoreboard's expected code word for that write and for the following write, and by the arm and counter read-back afterwards.

// File: rtl/ecc_inj_pkg.sv
package ecc_inj_pkg;

   localparam int NUM_FIELDS = 6;
   localparam int REG_AW     = 4;

   // register port addresses
   typedef enum logic [REG_AW-1:0] {
      RA_ENABLE  = 4'd0,
      RA_TYPE    = 4'd1,
      RA_SECTION = 4'd2,
      RA_MASK    = 4'd3,
      RA_F_DIMM  = 4'd4,
      RA_F_RANK  = 4'd5,
      RA_F_CHAN  = 4'd6,
      RA_F_BANK  = 4'd7,
      RA_F_PAGE  = 4'd8,
      RA_F_COL   = 4'd9,
      RA_COUNT   = 4'd10
   } reg_addr_e;

   // bit positions inside the type register
   localparam int TYPE_REPEAT = 0;
   localparam int TYPE_ECC    = 1;
   localparam int TYPE_PARITY = 2;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/ecc_inj_regs.sv
module ecc_inj_regs
   import ecc_inj_pkg::*;
#(
   parameter int REG_DW = 64,
   parameter int HALF_W = 36,
   parameter int CNT_W  = 8,
   parameter int MAXW   = 16,
   parameter int FW [NUM_FIELDS] = '{2, 2, 2, 3, 16, 10}
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              reg_we,
   input  logic [REG_AW-1:0]                 reg_addr,
   input  logic [REG_DW-1:0]                 reg_wdata,
   output logic [REG_DW-1:0]                 reg_rdata,
   input  logic                              hit,
   output logic                              armed,
   output logic                              repeat_en,
   output logic                              ecc_en,
   output logic                              par_en,
   output logic [1:0]                        section,
   output logic [HALF_W-1:0]                 mask,
   output logic [NUM_FIELDS-1:0][MAXW-1:0]   flt_val,
   output logic [NUM_FIELDS-1:0]             flt_any,
   output logic [CNT_W-1:0]                  count
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   logic [2:0]                       type_q;
   logic [NUM_FIELDS-1:0][MAXW-1:0]  fld_mask;
   logic                             wr_enable;

   // per-field value masks
   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fmask
      assign fld_mask[g] = MAXW'((64'd1 << FW[g]) - 64'd1);
   end

   assign wr_enable = reg_we && (reg_addr == RA_ENABLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed   <= 1'b0;
         type_q  <= '0;
         section <= '0;
         mask    <= '0;
         flt_val <= '0;
         flt_any <= '1;
         count   <= '0;
      end else begin
         // injection side effects first; software writes below win
         if (hit && !type_q[TYPE_REPEAT]) armed <= 1'b0;
         if (hit && count != CNT_MAX)     count <= count + 1'b1;
         if (wr_enable) begin
            armed <= |reg_wdata;
            if (|reg_wdata) count <= '0;
         end
         if (reg_we) begin
            case (reg_addr)
               RA_TYPE:    type_q  <= reg_wdata[2:0];
               RA_SECTION: section <= reg_wdata[1:0];
               RA_MASK:    mask    <= reg_wdata[HALF_W-1:0];
               default: begin
                  for (int i = 0; i < NUM_FIELDS; i++) begin
                     if (reg_addr == REG_AW'(int'(RA_F_DIMM) + i)) begin
                        flt_val[i] <= reg_wdata[MAXW-1:0] & fld_mask[i];
                        flt_any[i] <= reg_wdata[REG_DW-1];
                     end
                  end
               end
            endcase
         end
      end
   end

   assign repeat_en = type_q[TYPE_REPEAT];
   assign ecc_en    = type_q[TYPE_ECC];
   assign par_en    = type_q[TYPE_PARITY];

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_ENABLE:  reg_rdata[0]          = armed;
         RA_TYPE:    reg_rdata[2:0]        = type_q;
         RA_SECTION: reg_rdata[1:0]        = section;
         RA_MASK:    reg_rdata[HALF_W-1:0] = mask;
         RA_COUNT:   reg_rdata[CNT_W-1:0]  = count;
         default: begin
            for (int i = 0; i < NUM_FIELDS; i++) begin
               if (reg_addr == REG_AW'(int'(RA_F_DIMM) + i)) begin
                  reg_rdata[MAXW-1:0]   = flt_val[i];
                  reg_rdata[REG_DW-1]   = flt_any[i];
               end
            end
         end
      endcase
   end

endmodule

// File: rtl/ecc_inj_match.sv
module ecc_inj_match
   import ecc_inj_pkg::*;
#(
   parameter int MAXW = 16
) (
   input  logic [NUM_FIELDS-1:0][MAXW-1:0] addr_f,
   input  logic [NUM_FIELDS-1:0][MAXW-1:0] flt_val,
   input  logic [NUM_FIELDS-1:0]           flt_any,
   output logic                            match
);

   logic [NUM_FIELDS-1:0] fld_ok;

   for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
      assign fld_ok[g] = flt_any[g] || (addr_f[g] == flt_val[g]);
   end

   assign match = &fld_ok;

endmodule

// File: rtl/ecc_inj_corrupt.sv
module ecc_inj_corrupt #(
   parameter int HALF_W  = 36,
   parameter int PAR_POS = 35
) (
   input  logic [2*HALF_W-1:0] code_in,
   input  logic                hit,
   input  logic                ecc_en,
   input  logic                par_en,
   input  logic [1:0]          section,
   input  logic [HALF_W-1:0]   mask,
   output logic [2*HALF_W-1:0] code_out
);

   localparam logic [HALF_W-1:0] PAR_ONE = HALF_W'(1) << PAR_POS;

   logic [HALF_W-1:0] flip;

   assign flip = (ecc_en ? mask : '0) ^ (par_en ? PAR_ONE : '0);

   // section bit h enables half h
   for (genvar h = 0; h < 2; h++) begin : g_half
      assign code_out[h*HALF_W +: HALF_W] =
         code_in[h*HALF_W +: HALF_W] ^ ((hit && section[h]) ? flip : '0);
   end

endmodule

// File: rtl/ecc_inject_ctrl.sv
module ecc_inject_ctrl
   import ecc_inj_pkg::*;
#(
   parameter int DIMM_W = 2,
   parameter int RANK_W = 2,
   parameter int CHAN_W = 2,
   parameter int BANK_W = 3,
   parameter int PAGE_W = 16,
   parameter int COL_W  = 10,
   parameter int HALF_W = 36,
   parameter int REG_DW = 64,
   parameter int CNT_W  = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_we,
   input  logic [REG_AW-1:0]   reg_addr,
   input  logic [REG_DW-1:0]   reg_wdata,
   output logic [REG_DW-1:0]   reg_rdata,
   input  logic                in_valid,
   input  logic [DIMM_W-1:0]   in_dimm,
   input  logic [RANK_W-1:0]   in_rank,
   input  logic [CHAN_W-1:0]   in_chan,
   input  logic [BANK_W-1:0]   in_bank,
   input  logic [PAGE_W-1:0]   in_page,
   input  logic [COL_W-1:0]    in_col,
   input  logic [2*HALF_W-1:0] in_code,
   output logic                out_valid,
   output logic [2*HALF_W-1:0] out_code,
   output logic                out_injected
);

   localparam int FW [NUM_FIELDS] = '{DIMM_W, RANK_W, CHAN_W, BANK_W, PAGE_W, COL_W};
   localparam int MAXW = max2(max2(max2(DIMM_W, RANK_W), max2(CHAN_W, BANK_W)),
                              max2(PAGE_W, COL_W));
   localparam int PAR_POS = HALF_W - 1;

   // elaboration-time parameter checks
   if (REG_DW <= MAXW) begin : g_bad_field
      $error("REG_DW must exceed the widest filter field");
   end
   if (REG_DW < HALF_W) begin : g_bad_mask
      $error("REG_DW must hold the flip mask");
   end
   if (CNT_W < 1 || CNT_W > REG_DW) begin : g_bad_cnt
      $error("CNT_W out of range");
   end
   if (HALF_W < 2) begin : g_bad_half
      $error("HALF_W too small");
   end

   logic                            armed_q;
   logic                            repeat_en;
   logic                            ecc_en;
   logic                            par_en;
   logic [1:0]                      section;
   logic [HALF_W-1:0]               mask;
   logic [NUM_FIELDS-1:0][MAXW-1:0] flt_val;
   logic [NUM_FIELDS-1:0]           flt_any;
   logic [CNT_W-1:0]                count_q;
   logic [NUM_FIELDS-1:0][MAXW-1:0] addr_f;
   logic                            match;
   logic                            hit;
   logic [2*HALF_W-1:0]             code_mod;

   assign addr_f[0] = MAXW'(in_dimm);
   assign addr_f[1] = MAXW'(in_rank);
   assign addr_f[2] = MAXW'(in_chan);
   assign addr_f[3] = MAXW'(in_bank);
   assign addr_f[4] = MAXW'(in_page);
   assign addr_f[5] = MAXW'(in_col);

   ecc_inj_regs #(
      .REG_DW (REG_DW),
      .HALF_W (HALF_W),
      .CNT_W  (CNT_W),
      .MAXW   (MAXW),
      .FW     (FW)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_we    (reg_we),
      .reg_addr  (reg_addr),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .hit       (hit),
      .armed     (armed_q),
      .repeat_en (repeat_en),
      .ecc_en    (ecc_en),
      .par_en    (par_en),
      .section   (section),
      .mask      (mask),
      .flt_val   (flt_val),
      .flt_any   (flt_any),
      .count     (count_q)
   );

   ecc_inj_match #(
      .MAXW (MAXW)
   ) u_match (
      .addr_f  (addr_f),
      .flt_val (flt_val),
      .flt_any (flt_any),
      .match   (match)
   );

   assign hit = in_valid && armed_q && match;

   ecc_inj_corrupt #(
      .HALF_W  (HALF_W),
      .PAR_POS (PAR_POS)
   ) u_corrupt (
      .code_in  (in_code),
      .hit      (hit),
      .ecc_en   (ecc_en),
      .par_en   (par_en),
      .section  (section),
      .mask     (mask),
      .code_out (code_mod)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid    <= 1'b0;
         out_code     <= '0;
         out_injected <= 1'b0;
      end else begin
         out_valid    <= in_valid;
         out_code     <= code_mod;
         out_injected <= hit;
      end
   end

endmodule

// File: rtl/ecc_inj_chk.sv
module ecc_inj_chk #(
   parameter int CW     = 72,
   parameter int REG_DW = 64,
   parameter int CNT_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_we,
   input logic [3:0]        reg_addr,
   input logic [REG_DW-1:0] reg_wdata,
   input logic              in_valid,
   input logic [CW-1:0]     in_code,
   input logic              out_valid,
   input logic [CW-1:0]     out_code,
   input logic              out_injected,
   input logic              hit,
   input logic              armed,
   input logic              repeat_en,
   input logic [CNT_W-1:0]  count
);

   logic past_ok;
   logic arm_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assign arm_wr = reg_we && (reg_addr == 4'd0);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (out_valid == $past(in_valid))); // R11
   AST_PASS_UNLESS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !out_injected) |-> (out_code == $past(in_code))); // R11
   AST_INJECT_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && out_injected) |-> ($past(armed) && $past(in_valid))); // R9
   AST_ONESHOT_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !repeat_en && !arm_wr) |=> !armed); // R7
   AST_REPEAT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && repeat_en && !arm_wr) |=> armed); // R8
   AST_COUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!hit && !arm_wr) |=> $stable(count)); // R10
   AST_ARM_CLEARS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_wr && (|reg_wdata)) |=> (armed && count == '0)); // R9

endmodule

bind ecc_inject_ctrl ecc_inj_chk #(
   .CW     (2*HALF_W),
   .REG_DW (REG_DW),
   .CNT_W  (CNT_W)
) i_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .reg_we       (reg_we),
   .reg_addr     (reg_addr),
   .reg_wdata    (reg_wdata),
   .in_valid     (in_valid),
   .in_code      (in_code),
   .out_valid    (out_valid),
   .out_code     (out_code),
   .out_injected (out_injected),
   .hit          (hit),
   .armed        (armed_q),
   .repeat_en    (repeat_en),
   .count        (count_q)
);

// File: tb/test_ecc_inject_ctrl.sv
module test_ecc_inject_ctrl;
   import ecc_inj_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int FWB [6] = '{2, 2, 2, 3, 16, 10};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        in_valid = 1'b0;
   logic [1:0]  in_dimm = '0;
   logic [1:0]  in_rank = '0;
   logic [1:0]  in_chan = '0;
   logic [2:0]  in_bank = '0;
   logic [15:0] in_page = '0;
   logic [9:0]  in_col = '0;
   logic [71:0] in_code = '0;
   logic        out_valid;
   logic [71:0] out_code;
   logic        out_injected;

   int n_checks = 0;
   int n_errs   = 0;
   bit done     = 1'b0;

   // bench model of the programmed state
   bit          m_armed;
   logic [2:0]  m_type;
   logic [1:0]  m_sec;
   logic [35:0] m_mask;
   int          m_val [6];
   bit          m_any [6];
   int          m_count;

   // scoreboard queues
   logic [71:0] q_code [$];
   bit          q_hit  [$];
   string       q_tag  [$];

   always #(CLK_PERIOD/2) clk = ~clk;

   ecc_inject_ctrl i_ecc_inject_ctrl (
      .clk (clk), .rst_n (rst_n),
      .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .in_valid (in_valid), .in_dimm (in_dimm), .in_rank (in_rank), .in_chan (in_chan),
      .in_bank (in_bank), .in_page (in_page), .in_col (in_col), .in_code (in_code),
      .out_valid (out_valid), .out_code (out_code), .out_injected (out_injected)
   );

   task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errs++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // monitor: pops expected writes as they leave the block
   always @(negedge clk) begin
      if (rst_n && !done && out_valid) begin
         if (q_code.size() == 0) begin
            check("R11 unexpected out_valid", 72'(out_valid), 72'(0));
         end else begin
            logic [71:0] ec;
            bit          eh;
            string       et;
            ec = q_code.pop_front();
            eh = q_hit.pop_front();
            et = q_tag.pop_front();
            check({et, " code"}, out_code, ec);
            check({et, " injected"}, 72'(out_injected), 72'(eh));
         end
      end
   end

   task automatic model_reg(input logic [3:0] a, input logic [63:0] wd);
      case (a)
         4'd0: begin m_armed = |wd; if (|wd) m_count = 0; end
         4'd1: m_type = wd[2:0];
         4'd2: m_sec  = wd[1:0];
         4'd3: m_mask = wd[35:0];
         4'd4, 4'd5, 4'd6, 4'd7, 4'd8, 4'd9: begin
            int i;
            i = int'(a) - 4;
            m_val[i] = int'(wd[15:0]) & ((1 << FWB[i]) - 1);
            m_any[i] = wd[63];
         end
         default: ;
      endcase
   endtask

   // one cycle: optional data write and optional register write
   task automatic drive(input bit do_wr, input int fv [6], input logic [71:0] code,
                        input bit do_reg, input logic [3:0] a, input logic [63:0] wd,
                        input string tag);
      bit          mt;
      bit          hit;
      logic [71:0] exp;
      logic [35:0] flip;
      @(negedge clk);
      in_valid = do_wr;
      in_dimm = 2'(fv[0]); in_rank = 2'(fv[1]); in_chan = 2'(fv[2]);
      in_bank = 3'(fv[3]); in_page = 16'(fv[4]); in_col = 10'(fv[5]);
      in_code = code;
      reg_we = do_reg; reg_addr = a; reg_wdata = wd;
      mt = 1'b1;
      for (int i = 0; i < 6; i++) if (!m_any[i] && m_val[i] != fv[i]) mt = 1'b0;
      hit = do_wr && m_armed && mt;
      exp = code;
      flip = (m_type[1] ? m_mask : 36'd0) ^ (m_type[2] ? (36'd1 << 35) : 36'd0);
      if (hit && m_sec[0]) exp[35:0]  = exp[35:0]  ^ flip;
      if (hit && m_sec[1]) exp[71:36] = exp[71:36] ^ flip;
      if (do_wr) begin
         q_code.push_back(exp); q_hit.push_back(hit); q_tag.push_back(tag);
      end
      if (hit && !m_type[0]) m_armed = 1'b0;
      if (hit && m_count < 255) m_count++;
      if (do_reg) model_reg(a, wd);
      @(posedge clk);
      #1;
      in_valid = 1'b0;
      reg_we = 1'b0;
   endtask

   task automatic wreg(input logic [3:0] a, input logic [63:0] wd);
      drive(1'b0, '{0, 0, 0, 0, 0, 0}, 72'd0, 1'b1, a, wd, "reg");
   endtask

   task automatic wdat(input int fv [6], input logic [71:0] code, input string tag);
      drive(1'b1, fv, code, 1'b0, 4'd0, 64'd0, tag);
   endtask

   task automatic rchk(input logic [3:0] a, input logic [63:0] exp, input string tag);
      @(negedge clk);
      reg_addr = a;
      #1;
      check(tag, 72'(reg_rdata), 72'(exp));
   endtask

   task automatic drain();
      repeat (3) @(negedge clk);
      check("R11 scoreboard drained", 72'(q_code.size()), 72'(0));
   endtask

   task automatic all_any();
      for (int i = 0; i < 6; i++) wreg(4'(4 + i), 64'h8000_0000_0000_0000);
   endtask

   localparam logic [71:0] C0 = 72'hA5_1234_5678_9ABC_DEF0;
   localparam logic [71:0] C1 = 72'h3C_0F0F_F0F0_5555_AAAA;

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         n_errs++; n_checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
         $finish;
      end
   end

   initial begin
      m_armed = 0; m_type = 0; m_sec = 0; m_mask = 0; m_count = 0;
      for (int i = 0; i < 6; i++) begin m_val[i] = 0; m_any[i] = 1; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 out_valid after reset", 72'(out_valid), 72'(0));
      rchk(4'd0, 64'd0, "R1 armed after reset");
      rchk(4'd1, 64'd0, "R1 type after reset");
      rchk(4'd2, 64'd0, "R1 section after reset");
      rchk(4'd3, 64'd0, "R1 mask after reset");
      rchk(4'd10, 64'd0, "R1 count after reset");
      for (int i = 0; i < 6; i++) rchk(4'(4 + i), 64'h8000_0000_0000_0000, "R1 filter any after reset");

      // R11 disarmed pass-through
      wdat('{0, 0, 0, 0, 0, 0}, C0, "R11 disarmed write");
      drain();

      // R2 read-back and masking
      wreg(4'd3, 64'hFFFF_FFF1_2345_6789);
      rchk(4'd3, 64'h0000_0001_2345_6789, "R2 mask readback");
      wreg(4'd1, 64'h5);
      rchk(4'd1, 64'h5, "R2 type readback");
      wreg(4'd2, 64'h2);
      rchk(4'd2, 64'h2, "R2 section readback");
      wreg(4'd8, 64'h0000_0000_0001_2345);
      rchk(4'd8, 64'h2345, "R2 page value masked, any clear");
      wreg(4'd7, 64'h8000_0000_0000_00FF);
      rchk(4'd7, 64'h8000_0000_0000_0007, "R2 bank value masked, any set");
      wreg(4'd10, 64'h55);
      rchk(4'd10, 64'd0, "R2 count write ignored");
      rchk(4'd15, 64'd0, "R2 unused address reads zero");
      all_any();

      // R4 R5 R7 lower half, ECC, one-shot
      wreg(4'd1, 64'h2); wreg(4'd2, 64'h1); wreg(4'd3, 64'h8_0000_0003);
      wreg(4'd0, 64'h1);
      rchk(4'd0, 64'h1, "R9 armed by nonzero write");
      wdat('{0, 0, 0, 0, 0, 0}, C0, "R4 R5 lower half flip");
      wdat('{0, 0, 0, 0, 0, 0}, C1, "R7 second write after one-shot");
      drain();
      rchk(4'd0, 64'h0, "R7 one-shot disarmed");
      rchk(4'd10, 64'h1, "R10 count after one-shot");

      // R4 upper half
      wreg(4'd2, 64'h2); wreg(4'd0, 64'h7);
      rchk(4'd10, 64'h0, "R9 arming clears count");
      wdat('{1, 2, 3, 4, 5, 6}, C1, "R4 upper half flip");
      // R4 R6 both halves with ECC and parity combined
      wreg(4'd1, 64'h6); wreg(4'd2, 64'h3); wreg(4'd0, 64'h1);
      wdat('{0, 0, 0, 0, 0, 0}, C0, "R6 both halves ecc plus parity");
      // R6 parity only
      wreg(4'd1, 64'h4); wreg(4'd0, 64'h1);
      wdat('{0, 0, 0, 0, 0, 0}, C1, "R6 parity bits 35 and 71");
      // R4 section zero: counted but unchanged
      wreg(4'd1, 64'h2); wreg(4'd2, 64'h0); wreg(4'd0, 64'h1);
      wdat('{0, 0, 0, 0, 0, 0}, C0, "R4 section zero unchanged");
      drain();
      rchk(4'd10, 64'h1, "R4 section zero hit counted");

      // R11 invalid cycles do not consume a one-shot
      wreg(4'd2, 64'h1); wreg(4'd0, 64'h1);
      repeat (3) drive(1'b0, '{0, 0, 0, 0, 0, 0}, C0, 1'b0, 4'd0, 64'd0, "idle");
      rchk(4'd0, 64'h1, "R11 idle keeps arm");

      // R3 filter with R8 continuous injection
      wreg(4'd4, 64'h1); wreg(4'd7, 64'h5);
      wreg(4'd1, 64'h3); wreg(4'd0, 64'h1);
      wdat('{1, 0, 0, 5, 0, 0}, C0, "R3 matching write");
      wdat('{2, 0, 0, 5, 0, 0}, C0, "R3 module mismatch");
      wdat('{1, 0, 0, 4, 0, 0}, C1, "R3 bank mismatch");
      wdat('{1, 3, 2, 5, 16'hBEEF, 10'h3FF}, C1, "R3 R8 wildcard fields match");
      drain();
      rchk(4'd0, 64'h1, "R8 continuous stays armed");
      rchk(4'd10, 64'h2, "R10 count two hits");
      wreg(4'd0, 64'h0);
      wdat('{1, 0, 0, 5, 0, 0}, C0, "R8 after disarm");
      all_any();

      // R9 collision: disarm in the hit cycle of a continuous injection
      wreg(4'd0, 64'h1);
      drive(1'b1, '{0, 0, 0, 0, 0, 0}, C1, 1'b1, 4'd0, 64'h0, "R9 hit with disarm same cycle");
      wdat('{0, 0, 0, 0, 0, 0}, C1, "R9 write after disarm");
      drain();
      rchk(4'd0, 64'h0, "R9 disarm wins");
      // R9 collision: re-arm in the hit cycle of a one-shot
      wreg(4'd1, 64'h2); wreg(4'd0, 64'h1);
      drive(1'b1, '{0, 0, 0, 0, 0, 0}, C0, 1'b1, 4'd0, 64'h1, "R9 one-shot hit with rearm");
      rchk(4'd0, 64'h1, "R9 rearm wins over self-disarm");
      rchk(4'd10, 64'h0, "R9 rearm clears count");
      wdat('{0, 0, 0, 0, 0, 0}, C1, "R9 injection after rearm");
      drain();
      rchk(4'd10, 64'h1, "R10 count after rearm hit");

      // R10 saturation
      wreg(4'd1, 64'h3); wreg(4'd0, 64'h1);
      for (int k = 0; k < 260; k++) wdat('{0, 0, 0, 0, 0, 0}, 72'(k), "R10 saturation run");
      drain();
      rchk(4'd10, 64'd255, "R10 count saturates");

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
      $finish;
   end

endmodule